// File: doc/BRIEF.md
# Two-Wire Switch Register Access Master

This block is the host-side master of a two-wire serial link used to read and write 16-bit registers at 16-bit addresses inside an attached switch device. A host presents one request (direction, address, write data) for a single cycle while the block is idle. The block then runs a complete frame on the clock and data lines and reports the end of the frame with a one-cycle `done` pulse. A read returns its result on `rdata`. An acknowledge the device never gave is reported on `err`.

Every frame has the same shape. It opens with a start sequence: the data line falls while the clock is high. Eight control bits follow, then the address bytes and the data bytes. Each byte the device must accept is followed by an acknowledge slot. The frame closes with a stop sequence that adds extra clock pulses before both lines are released. Line timing comes from a run-time half-period count in system clocks. An acknowledge slot that reads back 1 is polled again, up to a run-time limit on attempts.

Top module: `swreg_serial_master`

## Requirements
- R1: While reset is held, and while idle after reset, `sck_oe` and `sda_oe` are 0 (both lines released), and `busy`, `done`, `err` and `rdata` are 0.
- R2: A request with `req_valid` high while idle is accepted at that clock edge, and `busy` is high from the next cycle. `req_valid` has no effect while `busy` is high. With `req_valid` low the block stays idle.
- R3: Every line step lasts H system clocks, where H is `half_div`, or 1 when `half_div` is 0. The start sequence has 7 steps, every bit slot has 3 steps (low, high, low) and the stop sequence has 7 steps. `done` is seen high (14 + 3·S)·H clock edges after the accepting edge, where S is the number of bit slots in the frame.
- R4: Start sequence: clock low with data high, one full clock pulse, clock high again, data falls while the clock is high, clock falls, then data returns high.
- R5: Outside the start and stop sequences, the data line changes only while the clock is low. Bits from the master go out MSB first, and the device samples them on the rising clock.
- R6: The first 8 bits of every frame are 1011, then 100, then a direction bit: 1 for read, 0 for write.
- R7: The address follows the control bits, bits [7:0] first and then bits [15:8]. The direction bit and each address byte are followed by an acknowledge slot in which the master releases the data line, and a sample of 0 means acknowledged.
- R8: A write then sends data bits [7:0] and then bits [15:8], each followed by an acknowledge slot.
- R9: A read then receives bits [7:0] and bits [15:8] from the device, each sampled while the clock is high. The master answers the low byte with a driven 0 and the high byte with a driven 1. The received value appears on `rdata` when `done` pulses.
- R10: An acknowledge slot that samples 1 is repeated until it samples 0 or the number of attempts reaches L. L is `ack_limit`, or 1 when `ack_limit` is 0. When every slot ends with a 0, `err` is 0 at `done`.
- R11: If any slot uses up its L attempts without a 0, `err` is 1 at `done`, the frame still runs to its stop sequence, and `err` holds until the next request is accepted.
- R12: Stop sequence: data low with the clock low, clock rises, data rises while the clock is high, then two more low-high clock pulses, then both lines are released. `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_div | input | 16 | Half bit period in system clocks (0 acts as 1) |
| ack_limit | input | 8 | Maximum acknowledge attempts per slot (0 acts as 1) |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_read | input | 1 | 1 for a register read, 0 for a write |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| err | output | 1 | At least one acknowledge slot failed in the last frame |
| rdata | output | 16 | Data from the last read frame |
| sck_out | output | 1 | Clock line level when driven |
| sck_oe | output | 1 | Clock line drive enable |
| sda_out | output | 1 | Data line level when driven |
| sda_oe | output | 1 | Data line drive enable |
| sda_in | input | 1 | Sampled data line level |

## Verification
The checker assumes that `half_div` and `ack_limit` stay fixed while a frame runs, and that the device changes the data line only while the clock is low. The stimulus sets both settings only in the cycle that carries the request. The device model in the bench changes its data only right after a falling clock edge, and it releases the line as soon as its slot ends. The model decodes every frame from the line levels alone. It refuses acknowledges a chosen number of times per slot, both below and at the attempt limit.

// File: rtl/swreg_serial_master.sv
`timescale 1ns/1ps
module swreg_serial_master #(
  parameter int DIV_W   = 16,
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   half_div,
  input  logic [RETRY_W-1:0] ack_limit,
  input  logic               req_valid,
  input  logic               req_read,
  input  logic [15:0]        req_addr,
  input  logic [15:0]        req_wdata,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [15:0]        rdata,
  output logic               sck_out,
  output logic               sck_oe,
  output logic               sda_out,
  output logic               sda_oe,
  input  logic               sda_in
);

  localparam logic [DIV_W-1:0]   ONE_D = 1;
  localparam logic [RETRY_W-1:0] ONE_R = 1;

  typedef enum logic [1:0] {IDLE = 2'd0, START = 2'd1, BITS = 2'd2, STOP = 2'd3} st_t;

  st_t               st;
  logic [DIV_W-1:0]  div_cnt;
  logic [2:0]        step;
  logic [1:0]        ph;
  logic [3:0]        fi;
  logic [2:0]        bi;
  logic [RETRY_W-1:0] tries;
  logic              rd_q, smp;
  logic [15:0]       addr_q, wdat_q;
  logic [7:0]        fbyte;
  logic              n_sck, n_sck_oe, n_sda, n_sda_oe;

  wire [DIV_W-1:0]   hd      = (half_div == '0) ? ONE_D : half_div;
  wire [RETRY_W-1:0] lim     = (ack_limit == '0) ? ONE_R : ack_limit;
  wire               tick    = (div_cnt == '0);
  wire               is_ack  = fi[0] && (!rd_q || fi < 4'd6);
  wire               is_rdat = rd_q && (fi == 4'd6 || fi == 4'd8);
  wire               rx      = is_ack || is_rdat;

  assign busy = (st != IDLE);

  always_comb begin
    case (fi)
      4'd0:    fbyte = {4'b1011, 3'b100, rd_q};
      4'd2:    fbyte = addr_q[7:0];
      4'd4:    fbyte = addr_q[15:8];
      4'd6:    fbyte = wdat_q[7:0];
      4'd8:    fbyte = wdat_q[15:8];
      4'd9:    fbyte = 8'h01;
      default: fbyte = 8'h00;
    endcase
  end

  always_comb begin
    n_sck_oe = 1'b1;
    n_sda_oe = 1'b1;
    n_sck    = 1'b0;
    n_sda    = 1'b1;
    unique case (st)
      IDLE: begin
        n_sck_oe = 1'b0;
        n_sda_oe = 1'b0;
        n_sck    = 1'b1;
      end
      START: begin
        n_sck = (step == 3'd1) || (step == 3'd3) || (step == 3'd4);
        n_sda = !((step == 3'd4) || (step == 3'd5));
      end
      BITS: begin
        n_sck    = (ph == 2'd1);
        n_sda_oe = !rx;
        n_sda    = fbyte[bi];
      end
      STOP: begin
        n_sck = (step == 3'd1) || (step == 3'd2) || (step == 3'd4) || (step == 3'd6);
        n_sda = (step >= 3'd2);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_out <= 1'b1;
      sck_oe  <= 1'b0;
      sda_out <= 1'b1;
      sda_oe  <= 1'b0;
    end else begin
      sck_out <= n_sck;
      sck_oe  <= n_sck_oe;
      sda_out <= n_sda;
      sda_oe  <= n_sda_oe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      div_cnt <= '0;
      step    <= 3'd0;
      ph      <= 2'd0;
      fi      <= 4'd0;
      bi      <= 3'd0;
      tries   <= '0;
      rd_q    <= 1'b0;
      smp     <= 1'b0;
      addr_q  <= 16'h0;
      wdat_q  <= 16'h0;
      done    <= 1'b0;
      err     <= 1'b0;
      rdata   <= 16'h0;
    end else begin
      done <= 1'b0;
      if (st == IDLE) begin
        if (req_valid) begin
          st      <= START;
          step    <= 3'd0;
          div_cnt <= hd - ONE_D;
          rd_q    <= req_read;
          addr_q  <= req_addr;
          wdat_q  <= req_wdata;
          err     <= 1'b0;
        end
      end else if (!tick) begin
        div_cnt <= div_cnt - ONE_D;
      end else begin
        div_cnt <= hd - ONE_D;
        case (st)
          START:
            if (step == 3'd6) begin
              st    <= BITS;
              fi    <= 4'd0;
              bi    <= 3'd7;
              ph    <= 2'd0;
              tries <= ONE_R;
            end else begin
              step <= step + 3'd1;
            end
          BITS:
            if (ph != 2'd2) begin
              ph <= ph + 2'd1;
              if (ph == 2'd1 && rx) begin
                smp <= sda_in;
                if (is_rdat) rdata[{fi[3], bi}] <= sda_in;
              end
            end else begin
              ph <= 2'd0;
              if (is_ack && smp && tries < lim) begin
                tries <= tries + ONE_R;
              end else if (bi != 3'd0) begin
                bi <= bi - 3'd1;
              end else begin
                if (is_ack && smp) err <= 1'b1;
                tries <= ONE_R;
                if (fi == 4'd9) begin
                  st   <= STOP;
                  step <= 3'd0;
                end else begin
                  fi <= fi + 4'd1;
                  bi <= fi[0] ? 3'd7 : 3'd0;
                end
              end
            end
          STOP:
            if (step == 3'd6) begin
              st   <= IDLE;
              done <= 1'b1;
            end else begin
              step <= step + 3'd1;
            end
          default: st <= IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/swreg_serial_master_chk.sv
`timescale 1ns/1ps
module swreg_serial_master_chk #(
  parameter int RETRY_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         state,
  input logic [RETRY_W-1:0] tries,
  input logic [RETRY_W-1:0] lim,
  input logic [15:0]        addr_q,
  input logic               req_valid,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic               sck_out,
  input logic               sck_oe,
  input logic               sda_out,
  input logic               sda_oe
);

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_BITS = 2'd2;

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state) == S_IDLE) |-> (!sck_oe && !sda_oe));

  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(addr_q));

  // R5
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BITS && $past(state) == S_BITS && sck_out && $past(sck_out))
      |-> ($stable(sda_out) && $stable(sda_oe)));

  // R10
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BITS) |-> (tries <= lim));

  // R11
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(state) == S_BITS));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind swreg_serial_master swreg_serial_master_chk #(.RETRY_W(RETRY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(st), .tries(tries), .lim(lim),
  .addr_q(addr_q), .req_valid(req_valid), .busy(busy), .done(done), .err(err),
  .sck_out(sck_out), .sck_oe(sck_oe), .sda_out(sda_out), .sda_oe(sda_oe)
);

// File: tb/swreg_serial_master_test.sv
`timescale 1ns/1ps
module swreg_serial_master_test;

  logic        clk, rst_n;
  logic [15:0] half_div;
  logic [7:0]  ack_limit;
  logic        req_valid, req_read;
  logic [15:0] req_addr, req_wdata;
  wire         busy, done, err;
  wire  [15:0] rdata;
  wire         sck_out, sck_oe, sda_out, sda_oe;
  logic        slv_val;

  wire sck_line = sck_oe ? sck_out : 1'b1;
  wire sda_line = sda_oe ? sda_out : slv_val;

  swreg_serial_master uut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .ack_limit(ack_limit),
    .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .sck_out(sck_out), .sck_oe(sck_oe), .sda_out(sda_out), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int n_checks = 0, n_fail = 0;
  int cfg_nacks = 0, cfg_lim = 1;
  logic [15:0] cfg_rd = 16'h0;
  logic [7:0]  s_ctrl, sb;
  logic [15:0] s_addr, s_wd;
  logic        s_m0, s_m1;
  int s_polls = 0, s_frames = 0, m_rise = 0, m_hichg = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // device model
  task automatic s_rx(output logic [7:0] b);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      @(posedge sck_line);
      b = {b[6:0], sda_line};
    end
  endtask

  task automatic s_ack();
    int left, att;
    logic nk;
    left = cfg_nacks;
    att = 0;
    @(negedge sck_line);
    do begin
      nk = (left > 0);
      slv_val = nk;
      @(posedge sck_line);
      att++;
      s_polls++;
      @(negedge sck_line);
      slv_val = 1'b1;
      if (nk) left--;
    end while (nk && att < cfg_lim);
  endtask

  task automatic s_tx(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      slv_val = b[i];
      @(posedge sck_line);
      @(negedge sck_line);
    end
    slv_val = 1'b1;
  endtask

  task automatic s_mack(output logic m);
    @(posedge sck_line);
    m = sda_line;
    @(negedge sck_line);
  endtask

  initial begin
    slv_val = 1'b1;
    forever begin
      @(negedge sda_line);
      if (sck_line === 1'b1) begin
        s_rx(sb); s_ctrl = sb; s_ack();
        s_rx(sb); s_addr[7:0] = sb; s_ack();
        s_rx(sb); s_addr[15:8] = sb; s_ack();
        if (s_ctrl[0]) begin
          s_tx(cfg_rd[7:0]);  s_mack(s_m0);
          s_tx(cfg_rd[15:8]); s_mack(s_m1);
        end else begin
          s_rx(sb); s_wd[7:0] = sb; s_ack();
          s_rx(sb); s_wd[15:8] = sb; s_ack();
        end
        s_frames++;
      end
    end
  end

  initial forever begin
    @(posedge sck_line);
    m_rise++;
  end

  initial forever begin
    @(sda_line);
    if (sck_line === 1'b1) m_hichg++;
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 oe in reset", int'({sck_oe, sda_oe}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 lines released", int'({sck_oe, sda_oe}), 0);
    chk("R1 status", int'({busy, done, err}), 0);
    chk("R1 rdata", int'(rdata), 0);
  endtask

  task automatic run_frame(input logic rd, input logic [15:0] a, input logic [15:0] wd,
                           input logic [15:0] rdv, input int hdv, input int nk,
                           input int lim, input bit intrude);
    int hde, lime, att, slots, p, cnt, f0;
    logic err_exp;
    hde = (hdv == 0) ? 1 : hdv;
    lime = (lim == 0) ? 1 : lim;
    att = (nk < lime) ? nk + 1 : lime;
    err_exp = (nk >= lime);
    slots = rd ? 3 : 5;
    p = 14 + 3 * (45 + slots * (att - 1));
    cfg_nacks = nk;
    cfg_lim = lime;
    cfg_rd = rdv;
    s_polls = 0;
    m_rise = 0;
    m_hichg = 0;
    f0 = s_frames;
    @(negedge clk);
    half_div = 16'(hdv);
    ack_limit = 8'(lim);
    req_read = rd;
    req_addr = a;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~a;
    req_wdata = ~wd;
    chk("R2 busy after accept", int'(busy), 1);
    cnt = 1;
    while (!done) begin
      @(negedge clk);
      cnt++;
      if (intrude) begin
        req_valid = (cnt == 40);
        req_read = ~rd;
      end
    end
    req_valid = 1'b0;
    chk("R3 frame length", cnt - 1, p * hde);
    if (err_exp) chk("R11 err on exhausted ack", int'(err), 1);
    else chk("R10 err clear", int'(err), 0);
    @(negedge clk);
    chk("R12 done single cycle", int'(done), 0);
    chk("R12 lines released", int'({sck_oe, sda_oe, busy}), 0);
    chk("R2 one frame seen", s_frames - f0, 1);
    chk("R6 control bits", int'(s_ctrl), int'({4'b1011, 3'b100, rd}));
    chk("R7 address", int'(s_addr), int'(a));
    if (rd) begin
      chk("R9 read data", int'(rdata), int'(rdv));
      chk("R9 master answers", int'({s_m0, s_m1}), 1);
    end else begin
      chk("R8 write data", int'(s_wd), int'(wd));
    end
    chk("R10 ack polls", s_polls, slots * att);
    chk("R12 R4 rising edges", m_rise, 2 + 45 + slots * (att - 1) + 3);
    chk("R5 data change at clock high", m_hichg, 2);
    if (intrude) begin
      repeat (20) @(negedge clk);
      chk("R2 no frame from ignored request", s_frames - f0, 1);
      chk("R2 idle after ignored request", int'(busy), 0);
    end
  endtask

  task automatic t_idle();
    int seen;
    seen = 0;
    req_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy || sck_oe || sda_oe) seen++;
    end
    chk("R2 stays idle without request", seen, 0);
  endtask

  initial begin
    half_div = 16'd2;
    ack_limit = 8'd3;
    req_valid = 1'b0;
    req_read = 1'b0;
    req_addr = 16'h0;
    req_wdata = 16'h0;
    t_reset();
    run_frame(1'b0, 16'hA51C, 16'h3C96, 16'h0000, 2, 0, 3, 1'b0);
    run_frame(1'b1, 16'h0F81, 16'h0000, 16'hB2E7, 3, 0, 3, 1'b0);
    run_frame(1'b0, 16'h1234, 16'hFE01, 16'h0000, 1, 2, 4, 1'b0);
    run_frame(1'b1, 16'h8001, 16'h0000, 16'h5AC3, 2, 3, 3, 1'b0);
    repeat (5) @(negedge clk);
    chk("R11 err held after frame", int'(err), 1);
    run_frame(1'b0, 16'h00FF, 16'h8000, 16'h0000, 0, 0, 0, 1'b0);
    run_frame(1'b1, 16'hC0DE, 16'h0000, 16'h0001, 1, 1, 0, 1'b0);
    run_frame(1'b0, 16'h7E42, 16'h9119, 16'h0000, 2, 1, 2, 1'b1);
    t_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule